// File: doc/BRIEF.md
# Dual-Reload Down-Counting Timer

This block is one channel of a memory-mapped timer. A 32-bit counter steps down by one on every prescaled tick. When it sits at zero and a further tick arrives, the channel flags an expiry. In periodic mode it then reloads from a background value. In free-running mode it wraps to all ones. Software can build a rising time base by inverting the value it reads. Expiry events are latched in a raw status bit. A mask routes that bit to a level interrupt, and a write-one-to-clear register acknowledges it.

There are two load registers. The immediate one restarts the count at once and also sets the background value. The background one only changes what the next reload uses, so a period can be retuned without disturbing the current one. Software programs the control byte with the enable bit clear, then writes it again with the enable bit set. Counting, and the prescaler phase, start on that second write.

Top module: `dual_reload_timer`

## Requirements
- R1: After reset every readable register returns 0 and `irq` is low.
- R2: The counter changes only through a load write while control bit 7 (enable, 0x80) is clear. Counting begins on the write that sets bit 7. Writing 0 to control (select 2) stops the counter, which keeps its value.
- R3: Control bits [3:2] pick the tick rate: 0 gives one tick per clock, 1 one per 16 clocks, 2 or 3 one per 256 clocks. The prescaler restarts when enable goes from 0 to 1, so the first tick lands 1, 16 or 256 cycles after the enabling write.
- R4: A write to select 0 (immediate load) sets the counter and the background value in the same cycle. It takes priority over a tick, and select 0 reads back the last value written there.
- R5: A write to select 3 (background load) changes only the value used at the next reload. The running count is left alone.
- R6: With control bit 6 (periodic, 0x40) set, a tick at count 0 reloads the background value and sets the raw status bit.
- R7: With bit 6 clear, a tick at count 0 wraps the count to all ones and sets the raw status bit. The channel stays enabled.
- R8: With control bit 1 (0x02) set, the counter is 32 bits wide. With it clear, only the low 16 bits count, select 1 reads them zero-extended, and a wrap goes to 0xFFFF.
- R9: Select 4 bit 0 is the mask. `irq` and select 6 bit 0 equal the raw status ANDed with the mask.
- R10: Writing 1 to bit 0 of select 7 clears the raw status bit, which select 5 bit 0 reads. Writing 0 there has no effect, and an expiry in the same cycle wins over a clear.
- R11: Select 1 (count value) returns the current count. Writes to selects 1, 5 and 6 change nothing, and select 7 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe, one cycle |
| reg_sel | input | 3 | Register select |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `reg_sel`, combinational |
| irq | output | 1 | Level interrupt |

## Verification
A wrong count shows up on select 1 in the cycle after the faulty edge. The bench keeps that select on the bus while idle, so the error is seen within one clock. A prescaler off by one shifts every later value, and the error appears at the next tick at the latest. A lost or stuck status bit shows on `irq` as soon as the mask is set, which the bench compares on every cycle.

// File: rtl/dual_reload_timer.sv
module dual_reload_timer (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [2:0]  reg_sel,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        irq
);
  localparam logic [2:0] SEL_LOAD = 3'd0, SEL_VALUE = 3'd1, SEL_CTRL = 3'd2, SEL_BG = 3'd3,
                         SEL_MASK = 3'd4, SEL_RAW = 3'd5, SEL_MIS = 3'd6, SEL_CLR = 3'd7;

  logic [31:0] cnt_q, bg_q, ld_q;
  logic [7:0]  ctrl_q, pcnt_q;
  logic        raw_q, mask_q;

  wire en       = ctrl_q[7];
  wire periodic = ctrl_q[6];
  wire wide     = ctrl_q[1];

  wire [31:0] span = wide ? 32'hFFFF_FFFF : 32'h0000_FFFF;
  wire [31:0] cur  = cnt_q & span;

  logic [7:0] div_m1;
  always_comb begin
    case (ctrl_q[3:2])
      2'd0:    div_m1 = 8'd0;
      2'd1:    div_m1 = 8'd15;
      default: div_m1 = 8'd255;
    endcase
  end

  wire tick   = en && (pcnt_q >= div_m1);
  wire expire = tick && (cur == 32'd0);

  wire wr_ld   = wr_en && reg_sel == SEL_LOAD;
  wire wr_ctrl = wr_en && reg_sel == SEL_CTRL;
  wire wr_bg   = wr_en && reg_sel == SEL_BG;
  wire wr_mask = wr_en && reg_sel == SEL_MASK;
  wire wr_clr  = wr_en && reg_sel == SEL_CLR && wdata[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      bg_q   <= '0;
      ld_q   <= '0;
      ctrl_q <= '0;
      pcnt_q <= '0;
      raw_q  <= 1'b0;
      mask_q <= 1'b0;
    end else begin
      if (!en || tick) pcnt_q <= '0;
      else             pcnt_q <= pcnt_q + 8'd1;

      if (wr_ld) begin
        cnt_q <= wdata;
        ld_q  <= wdata;
      end else if (tick) begin
        if (expire) cnt_q <= periodic ? bg_q : span;
        else        cnt_q <= (cur - 32'd1) & span;
      end

      if (wr_ld || wr_bg) bg_q <= wdata;
      if (wr_ctrl) ctrl_q <= wdata[7:0];
      if (wr_mask) mask_q <= wdata[0];

      if (expire)      raw_q <= 1'b1;
      else if (wr_clr) raw_q <= 1'b0;
    end
  end

  assign irq = raw_q & mask_q;

  always_comb begin
    case (reg_sel)
      SEL_LOAD:  rdata = ld_q;
      SEL_VALUE: rdata = cur;
      SEL_CTRL:  rdata = {24'd0, ctrl_q};
      SEL_BG:    rdata = bg_q;
      SEL_MASK:  rdata = {31'd0, mask_q};
      SEL_RAW:   rdata = {31'd0, raw_q};
      SEL_MIS:   rdata = {31'd0, irq};
      default:   rdata = 32'd0;
    endcase
  end
endmodule

// File: rtl/dual_reload_timer_chk.sv
module dual_reload_timer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [2:0]  reg_sel,
  input logic [31:0] wdata,
  input logic [31:0] cnt_q,
  input logic [31:0] bg_q,
  input logic        raw_q,
  input logic        en,
  input logic        expire,
  input logic        irq
);
  assert_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_sel == 3'd0) |=> (cnt_q == $past(wdata) && bg_q == $past(wdata)));

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !(wr_en && reg_sel == 3'd0)) |=> cnt_q == $past(cnt_q));

  assert_bg_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_sel == 3'd3) |=> bg_q == $past(wdata));

  assert_expire_R6: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> raw_q);

  assert_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_sel == 3'd7 && wdata[0] && !expire) |=> !raw_q);

  assert_keep_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_sel == 3'd7 && !wdata[0] && raw_q) |=> raw_q);

  assert_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> raw_q);
endmodule

bind dual_reload_timer dual_reload_timer_chk chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .reg_sel(reg_sel), .wdata(wdata),
  .cnt_q(cnt_q), .bg_q(bg_q), .raw_q(raw_q), .en(en), .expire(expire), .irq(irq)
);

// File: tb/dual_reload_timer_test.sv
module dual_reload_timer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  reg_sel = 3'd1;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int tests = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 0;
  string cur_req = "R1";

  always #4 clk = ~clk;

  dual_reload_timer uut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .reg_sel(reg_sel),
                         .wdata(wdata), .rdata(rdata), .irq(irq));

  logic [31:0] m_cnt, m_bg, m_ld;
  logic [7:0]  m_ctrl;
  int          m_pc;
  bit          m_raw, m_mask;

  function automatic logic [31:0] m_read(input logic [2:0] s);
    logic [31:0] sz;
    sz = m_ctrl[1] ? 32'hFFFF_FFFF : 32'h0000_FFFF;
    case (s)
      3'd0: return m_ld;
      3'd1: return m_cnt & sz;
      3'd2: return {24'd0, m_ctrl};
      3'd3: return m_bg;
      3'd4: return {31'd0, m_mask};
      3'd5: return {31'd0, m_raw};
      3'd6: return {31'd0, m_raw & m_mask};
      default: return 32'd0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_bg = 0; m_ld = 0; m_ctrl = 0; m_pc = 0; m_raw = 0; m_mask = 0;
    end else begin
      logic [31:0] sz, v;
      int lim;
      bit en, tk, ex;
      en = m_ctrl[7];
      sz = m_ctrl[1] ? 32'hFFFF_FFFF : 32'h0000_FFFF;
      lim = (m_ctrl[3:2] == 0) ? 1 : (m_ctrl[3:2] == 1) ? 16 : 256;
      tk = en && (m_pc >= lim - 1);
      v = m_cnt & sz;
      ex = tk && (v == 0);
      m_pc = (!en || tk) ? 0 : m_pc + 1;
      if (wr_en && reg_sel == 0) begin m_cnt = wdata; m_ld = wdata; end
      else if (tk) m_cnt = ex ? (m_ctrl[6] ? m_bg : sz) : ((v - 1) & sz);
      if (wr_en && (reg_sel == 0 || reg_sel == 3)) m_bg = wdata;
      if (wr_en && reg_sel == 4) m_mask = wdata[0];
      if (ex) m_raw = 1;
      else if (wr_en && reg_sel == 7 && wdata[0]) m_raw = 0;
      if (wr_en && reg_sel == 2) m_ctrl = wdata[7:0];
    end
  end

  always @(posedge clk) begin
    #2;
    cycles++;
    if (rst_n && !done) begin
      tests++;
      if (rdata !== m_read(reg_sel)) begin
        fails++;
        $display("FAIL %s rdata sel=%0d got %h expected %h", cur_req, reg_sel, rdata, m_read(reg_sel));
      end
      tests++;
      if (irq !== (m_raw & m_mask)) begin
        fails++;
        $display("FAIL %s irq got %b expected %b", cur_req, irq, m_raw & m_mask);
      end
    end
    if (cycles > 150000 && !done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic wr(input logic [2:0] s, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; reg_sel = s; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; reg_sel = 3'd1;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    cur_req = "R1";
    for (int s = 0; s < 8; s++) begin
      reg_sel = s[2:0];
      #1;
      tests++;
      if (rdata !== 32'd0) begin
        fails++;
        $display("FAIL R1 reset sel=%0d got %h expected 0", s, rdata);
      end
      @(negedge clk);
    end
    tests++;
    if (irq !== 1'b0) begin fails++; $display("FAIL R1 irq got %b expected 0", irq); end
    reg_sel = 3'd1;

    cur_req = "R2";  wr(0, 5); idle(6); wr(2, 32'h42); idle(4);
    cur_req = "R6";  wr(4, 1); wr(2, 32'hC2); idle(20);
    cur_req = "R10"; wr(7, 0); idle(2); wr(7, 1); idle(3);
    cur_req = "R5";  wr(3, 2); idle(15);
    cur_req = "R4";  wr(0, 9); idle(3);
    cur_req = "R11"; wr(1, 32'hDEAD); wr(5, 0); wr(6, 0); reg_sel = 3'd7; idle(2); reg_sel = 3'd1;
    cur_req = "R2";  wr(2, 0); idle(5);
    cur_req = "R7";  wr(0, 2); wr(2, 32'h82); idle(8); wr(2, 0); wr(7, 1);
    cur_req = "R8";  wr(0, 32'h1234_0001); wr(2, 32'h80); idle(6); wr(2, 0);
    cur_req = "R3";  wr(0, 3); wr(2, 32'h46); wr(2, 32'hC6); idle(80);
    wr(2, 0); wr(0, 1); wr(2, 32'hCA); idle(600); wr(2, 32'hCE); idle(300);
    cur_req = "R9";  wr(4, 0); reg_sel = 3'd6; idle(300); wr(4, 1); reg_sel = 3'd6; idle(300);
    reg_sel = 3'd1;
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule